// File: doc/BRIEF.md
# Operand Bypass and Pipeline Interlock Control

This block is the hazard controller for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle the decode stage presents the instruction it holds: its two source register numbers with their use flags, its destination register, its write enable and whether it is a load. The execute stage reports whether the branch it holds resolved taken. From these inputs the block keeps its own record of which instruction sits in execute, memory and writeback. It then drives the controls the datapath needs for correct results without software-inserted no-ops.

For the instruction in execute, the block picks where each operand comes from: the register file, the writeback result or the memory-stage result. A load whose result is needed by the very next instruction cannot be forwarded in time. In that case fetch and decode hold for one cycle and a bubble enters execute. Branches are predicted not taken. When a branch in execute resolves taken, the two younger instructions in fetch and decode are annulled, and the annulled decode instruction never enters the record of later stages.

Top module: `hazard_unit`

## Requirements
- R1: After a synchronous active-low reset, with no instruction in decode, both operand selects read 0 (register file) and all hold, bubble and annul outputs are low.
- R2: When an execute-stage source in use matches the destination of a writing instruction in the memory stage, its select is 2 (memory result).
- R3: When an execute-stage source in use matches the destination of a writing instruction in writeback and not one in memory, its select is 1 (writeback result).
- R4: When both memory and writeback instructions write the matched register, the memory stage wins (select 2).
- R5: Register 0 is never forwarded and never causes a stall, even when a load targets it.
- R6: A source whose use flag is low, or a producer whose write enable is low, causes no forwarding.
- R7: A decode instruction reading the destination of a load in execute raises hold_if, hold_id and bubble_exe together for exactly one cycle, on either source.
- R8: After such a stall, the consumer reaches execute with the load in writeback and takes that operand with select 1.
- R9: A taken branch in execute raises kill_if and kill_id, and annulment suppresses any stall raised in the same cycle.
- R10: An instruction annulled in decode never enters execute: it neither stalls its successor nor is forwarded later.
- R11: A taken indication while execute holds a bubble has no effect on the annul outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | AW | First source register of the decode instruction |
| id_rs2 | input | AW | Second source register of the decode instruction |
| id_use1 | input | 1 | First source is read |
| id_use2 | input | 1 | Second source is read |
| id_rd | input | AW | Destination register of the decode instruction |
| id_wen | input | 1 | Decode instruction writes its destination |
| id_load | input | 1 | Decode instruction is a load |
| exe_taken | input | 1 | Branch in execute resolved taken |
| fwd_a | output | 2 | First operand source: 0 register file, 1 writeback, 2 memory |
| fwd_b | output | 2 | Second operand source, same encoding |
| hold_if | output | 1 | Hold the fetch register |
| hold_id | output | 1 | Hold the decode register |
| bubble_exe | output | 1 | Insert a no-op into execute |
| kill_if | output | 1 | Annul the fetched instruction |
| kill_id | output | 1 | Annul the decode instruction |

## Verification
The bench builds the block with the default register-address width of five bits, which gives the full 32-register namespace including register 0. That is enough to place distinct producers in memory and writeback at the same time, including two that write the same register, and to aim a load at register 0. Instruction sequences walk through plain forwarding, priority, load-use on each source, taken branches over an annulled load, and a taken flag raised over a bubble.

// File: rtl/hz_pkg.sv
// Shared encodings for the hazard controller.
// Assumes a two-bit operand source select consumed by the execute-stage muxes.
package hz_pkg;
    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_WB  = 2'd1,
        SRC_MEM = 2'd2
    } byp_e;
endpackage

// File: rtl/hz_shadow.sv
// Shadow record of the execute, memory and writeback stages.
// Assumes the pipeline advances every cycle; a non-filled execute slot is a no-op.
module hz_shadow #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fill,
    input  logic [NSRC-1:0][AW-1:0]   id_rs,
    input  logic [NSRC-1:0]           id_use,
    input  logic [AW-1:0]             id_rd,
    input  logic                      id_wen,
    input  logic                      id_load,
    output logic                      ex_v,
    output logic [NSRC-1:0][AW-1:0]   ex_rs,
    output logic [NSRC-1:0]           ex_use,
    output logic [AW-1:0]             ex_rd,
    output logic                      ex_wen,
    output logic                      ex_load,
    output logic                      mem_v,
    output logic [AW-1:0]             mem_rd,
    output logic                      mem_wen,
    output logic                      wb_v,
    output logic [AW-1:0]             wb_rd,
    output logic                      wb_wen
);
    // Execute slot: take the decode instruction or become a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_v    <= 1'b0;
            ex_rs   <= '0;
            ex_use  <= '0;
            ex_rd   <= '0;
            ex_wen  <= 1'b0;
            ex_load <= 1'b0;
        end else begin
            ex_v    <= fill;
            ex_rs   <= id_rs;
            ex_use  <= id_use & {NSRC{fill}};
            ex_rd   <= id_rd;
            ex_wen  <= id_wen & fill;
            ex_load <= id_load & fill;
        end
    end

    // Memory and writeback slots: plain shift of producer information.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_v   <= 1'b0;
            mem_rd  <= '0;
            mem_wen <= 1'b0;
            wb_v    <= 1'b0;
            wb_rd   <= '0;
            wb_wen  <= 1'b0;
        end else begin
            mem_v   <= ex_v;
            mem_rd  <= ex_rd;
            mem_wen <= ex_wen;
            wb_v    <= mem_v;
            wb_rd   <= mem_rd;
            wb_wen  <= mem_wen;
        end
    end
endmodule

// File: rtl/hz_bypass.sv
// Operand source select for one execute-stage source.
// Assumes register 0 reads as zero and is never produced by a later stage.
module hz_bypass
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          ex_v,
    input  logic          src_use,
    input  logic [AW-1:0] src,
    input  logic          mem_v,
    input  logic          mem_wen,
    input  logic [AW-1:0] mem_rd,
    input  logic          wb_v,
    input  logic          wb_wen,
    input  logic [AW-1:0] wb_rd,
    output logic [1:0]    sel
);
    logic live;
    logic mem_hit;
    logic wb_hit;

    // Qualify the source: real instruction, read, and not register 0.
    always_comb live = ex_v && src_use && (src != '0);

    // Match against each younger-to-older producer.
    always_comb begin
        mem_hit = live && mem_v && mem_wen && (mem_rd == src);
        wb_hit  = live && wb_v  && wb_wen  && (wb_rd  == src);
    end

    // Youngest producer wins.
    always_comb begin
        if (mem_hit)     sel = SRC_MEM;
        else if (wb_hit) sel = SRC_WB;
        else             sel = SRC_RF;
    end
endmodule

// File: rtl/hz_interlock.sv
// Load-use stall and branch annul decision.
// Assumes a load result is usable by forwarding only from writeback onward
// for the instruction right behind it; annulment outranks a stall.
module hz_interlock #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic                    id_valid,
    input  logic [NSRC-1:0][AW-1:0] id_rs,
    input  logic [NSRC-1:0]         id_use,
    input  logic                    ex_v,
    input  logic [AW-1:0]           ex_rd,
    input  logic                    ex_wen,
    input  logic                    ex_load,
    input  logic                    exe_taken,
    output logic                    hold,
    output logic                    kill,
    output logic                    fill
);
    logic [NSRC-1:0] hit;
    logic            load_use;

    // Per-source dependence on the load in execute.
    for (genvar s = 0; s < NSRC; s++) begin : g_dep
        always_comb hit[s] = id_use[s] && (id_rs[s] == ex_rd) && (ex_rd != '0);
    end

    // Combine dependence with the producer being a writing load.
    always_comb load_use = id_valid && ex_v && ex_load && ex_wen && (|hit);

    // Annul first, then stall, then decide whether decode advances.
    always_comb begin
        kill = ex_v && exe_taken;
        hold = load_use && !kill;
        fill = id_valid && !hold && !kill;
    end
endmodule

// File: rtl/hazard_unit.sv
// Hazard controller top: forwarding selects, load-use interlock, branch annul.
// Assumes branches resolve in execute, are predicted not taken, and that the
// datapath applies the hold/bubble/kill outputs in the same cycle.
module hazard_unit #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          id_valid,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_use1,
    input  logic          id_use2,
    input  logic [AW-1:0] id_rd,
    input  logic          id_wen,
    input  logic          id_load,
    input  logic          exe_taken,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          hold_if,
    output logic          hold_id,
    output logic          bubble_exe,
    output logic          kill_if,
    output logic          kill_id
);
    localparam int NSRC = 2;

    logic [NSRC-1:0][AW-1:0] id_rs;
    logic [NSRC-1:0]         id_use;
    logic                    ex_v, ex_wen, ex_load;
    logic [NSRC-1:0][AW-1:0] ex_rs;
    logic [NSRC-1:0]         ex_use;
    logic [AW-1:0]           ex_rd;
    logic                    mem_v, mem_wen, wb_v, wb_wen;
    logic [AW-1:0]           mem_rd, wb_rd;
    logic                    hold, kill, fill;
    logic [NSRC-1:0][1:0]    sel;

    // Gather decode sources into indexed form.
    always_comb begin
        id_rs  = {id_rs2, id_rs1};
        id_use = {id_use2, id_use1};
    end

    hz_interlock #(.AW(AW), .NSRC(NSRC)) u_lock (
        .id_valid (id_valid),
        .id_rs    (id_rs),
        .id_use   (id_use),
        .ex_v     (ex_v),
        .ex_rd    (ex_rd),
        .ex_wen   (ex_wen),
        .ex_load  (ex_load),
        .exe_taken(exe_taken),
        .hold     (hold),
        .kill     (kill),
        .fill     (fill)
    );

    hz_shadow #(.AW(AW), .NSRC(NSRC)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .fill   (fill),
        .id_rs  (id_rs),
        .id_use (id_use),
        .id_rd  (id_rd),
        .id_wen (id_wen),
        .id_load(id_load),
        .ex_v   (ex_v),
        .ex_rs  (ex_rs),
        .ex_use (ex_use),
        .ex_rd  (ex_rd),
        .ex_wen (ex_wen),
        .ex_load(ex_load),
        .mem_v  (mem_v),
        .mem_rd (mem_rd),
        .mem_wen(mem_wen),
        .wb_v   (wb_v),
        .wb_rd  (wb_rd),
        .wb_wen (wb_wen)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_byp
        hz_bypass #(.AW(AW)) u_byp (
            .ex_v   (ex_v),
            .src_use(ex_use[s]),
            .src    (ex_rs[s]),
            .mem_v  (mem_v),
            .mem_wen(mem_wen),
            .mem_rd (mem_rd),
            .wb_v   (wb_v),
            .wb_wen (wb_wen),
            .wb_rd  (wb_rd),
            .sel    (sel[s])
        );
    end

    // Drive the control outputs.
    always_comb begin
        fwd_a      = sel[0];
        fwd_b      = sel[1];
        hold_if    = hold;
        hold_id    = hold;
        bubble_exe = hold;
        kill_if    = kill;
        kill_id    = kill;
    end
endmodule

// File: rtl/hazard_unit_chk.sv
// Property checker for the hazard controller, attached by bind.
// Assumes the same clock and synchronous active-low reset as the top.
module hazard_unit_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] id_rs1,
    input logic [AW-1:0] id_rs2,
    input logic          hold_if,
    input logic          hold_id,
    input logic          bubble_exe,
    input logic          kill_if,
    input logic          kill_id
);
    // R9
    annul_over_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_if && kill_id) |-> !hold_if);

    // R7
    stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_if |=> !hold_if);

    // R7
    stall_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_if |-> (hold_id && bubble_exe));

    // R10
    annul_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_id |=> !hold_id);

    // R5
    zero_reg_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs1 == '0 && id_rs2 == '0) |-> !bubble_exe);
endmodule

bind hazard_unit hazard_unit_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_rs1    (id_rs1),
    .id_rs2    (id_rs2),
    .hold_if   (hold_if),
    .hold_id   (hold_id),
    .bubble_exe(bubble_exe),
    .kill_if   (kill_if),
    .kill_id   (kill_id)
);

// File: tb/tb_hazard_unit.sv
// Scoreboard bench: the driver pushes the expected controls for each cycle,
// the monitor pops and compares them a quarter period after the falling edge.
module tb_hazard_unit;
    localparam int CLK_P = 10;
    localparam int AW    = 5;

    typedef struct {
        logic [1:0] fa;
        logic [1:0] fb;
        logic       hold;
        logic       kill;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          id_valid = 1'b0;
    logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
    logic          id_use1 = 1'b0, id_use2 = 1'b0, id_wen = 1'b0, id_load = 1'b0;
    logic          exe_taken = 1'b0;
    logic [1:0]    fwd_a, fwd_b;
    logic          hold_if, hold_id, bubble_exe, kill_if, kill_id;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    hazard_unit #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use1(id_use1), .id_use2(id_use2),
        .id_rd(id_rd), .id_wen(id_wen), .id_load(id_load), .exe_taken(exe_taken),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .hold_if(hold_if), .hold_id(hold_id),
        .bubble_exe(bubble_exe), .kill_if(kill_if), .kill_id(kill_id)
    );

    task automatic cmp(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Driver: one call per cycle, drives decode inputs and queues expectations.
    task automatic cyc(input logic v, input int rs1, input int rs2, input logic u1,
                       input logic u2, input int rd, input logic wen, input logic ld,
                       input logic tk, input int fa, input int fb, input logic hold,
                       input logic kill, input string tag);
        exp_t e;
        @(negedge clk);
        id_valid  = v;
        id_rs1    = AW'(rs1);
        id_rs2    = AW'(rs2);
        id_use1   = u1;
        id_use2   = u2;
        id_rd     = AW'(rd);
        id_wen    = wen;
        id_load   = ld;
        exe_taken = tk;
        e.fa = 2'(fa); e.fb = 2'(fb); e.hold = hold; e.kill = kill; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input logic tk, input int fa, input int fb, input logic kill,
                        input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, tk, fa, fb, 0, kill, tag);
    endtask

    // Monitor: compare every output against the queued item.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "fwd_a", int'(fwd_a), int'(e.fa));
                cmp(e.tag, "fwd_b", int'(fwd_b), int'(e.fb));
                cmp(e.tag, "hold_if", int'(hold_if), int'(e.hold));
                cmp(e.tag, "hold_id", int'(hold_id), int'(e.hold));
                cmp(e.tag, "bubble_exe", int'(bubble_exe), int'(e.hold));
                cmp(e.tag, "kill_if", int'(kill_if), int'(e.kill));
                cmp(e.tag, "kill_id", int'(kill_id), int'(e.kill));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        idle(0, 0, 0, 0, "R1");
        // R2 R3 forwarding from memory and writeback
        cyc(1, 0, 0, 0, 0, 5, 1, 0, 0, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 0, 0, 6, 1, 0, 0, 0, 0, 0, 0, "R2");
        cyc(1, 5, 6, 1, 1, 7, 1, 0, 0, 0, 0, 0, 0, "R2");
        idle(0, 1, 2, 0, "R2_R3");
        // R4 memory over writeback
        cyc(1, 0, 0, 0, 0, 8, 1, 0, 0, 0, 0, 0, 0, "R4");
        cyc(1, 0, 0, 0, 0, 8, 1, 0, 0, 0, 0, 0, 0, "R4");
        cyc(1, 8, 8, 1, 1, 20, 1, 0, 0, 0, 0, 0, 0, "R4");
        idle(0, 2, 2, 0, "R4");
        // R5 register 0
        cyc(1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R5");
        cyc(1, 0, 0, 1, 1, 21, 1, 0, 0, 0, 0, 0, 0, "R5");
        idle(0, 0, 0, 0, "R5");
        // R6 no write enable, unused source
        cyc(1, 0, 0, 0, 0, 9, 0, 0, 0, 0, 0, 0, 0, "R6");
        cyc(1, 0, 0, 0, 0, 10, 1, 0, 0, 0, 0, 0, 0, "R6");
        cyc(1, 9, 10, 1, 0, 22, 1, 0, 0, 0, 0, 0, 0, "R6");
        idle(0, 0, 0, 0, "R6");
        idle(0, 0, 0, 0, "R6");
        idle(0, 0, 0, 0, "R6");
        // R7 R8 load-use on the first source
        cyc(1, 0, 0, 0, 0, 11, 1, 1, 0, 0, 0, 0, 0, "R7");
        cyc(1, 11, 3, 1, 1, 12, 1, 0, 0, 0, 0, 1, 0, "R7");
        cyc(1, 11, 3, 1, 1, 12, 1, 0, 0, 0, 0, 0, 0, "R7");
        idle(0, 1, 0, 0, "R8");
        // R7 R8 load-use on the second source
        cyc(1, 0, 0, 0, 0, 13, 1, 1, 0, 0, 0, 0, 0, "R7");
        cyc(1, 2, 13, 1, 1, 23, 1, 0, 0, 0, 0, 1, 0, "R7");
        cyc(1, 2, 13, 1, 1, 23, 1, 0, 0, 0, 0, 0, 0, "R7");
        idle(0, 0, 1, 0, "R8");
        // R9 R10 taken branch annuls a load in decode
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        cyc(1, 0, 0, 0, 0, 14, 1, 1, 1, 0, 0, 0, 1, "R9");
        cyc(1, 14, 0, 1, 0, 24, 1, 0, 0, 0, 0, 0, 0, "R10");
        idle(0, 0, 0, 0, "R10");
        // R9 annul outranks a same-cycle stall
        cyc(1, 0, 0, 0, 0, 15, 1, 1, 0, 0, 0, 0, 0, "R9");
        cyc(1, 15, 0, 1, 0, 25, 1, 0, 1, 0, 0, 0, 1, "R9");
        idle(0, 0, 0, 0, "R10");
        // R11 taken flag over a bubble
        idle(1, 0, 0, 0, "R11");
        @(negedge clk);
        exe_taken = 1'b0;
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_P * 2000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule